// File: doc/BRIEF.md
# Round-Robin Transmit Line Scanner

This block decides which of several serial lines the host should feed next. It combines a per-line transmit-enable mask with a per-line busy state that it keeps itself. From these it publishes a status word that carries a transmit-ready flag and the number of the chosen line. When the host writes a character, the block hands it to the selected line on a valid/ready output stream, marks that line busy for a fixed time, and searches again. The search starts just past the line it last reported, so all enabled lines get served in turn.

A control write sets two bits, master scan enable and transmit interrupt enable. The transmit interrupt request is high whenever interrupts are enabled and a line is ready. Downstream back-pressure works as follows. `tx_valid` stays high, with `tx_line` and `tx_char` stable, until a cycle with `tx_ready` high. While a character is still waiting, a new data write is not sent.

Top module: `txs_line_scanner`

## Requirements
- R1: After reset, `status_o` is 0x0000, `tx_irq_o` is 0 and `tx_valid` is 0.
- R2: A scan tests each line exactly once. It starts at the reported line field plus one and wraps modulo NUM_LINES. A line qualifies when its `txen_mask` bit is set and the line is idle. The first qualifying line is written to `status_o[10:8]` and `status_o[15]` (transmit ready) is set.
- R3: When no line qualifies, `status_o[15]` is cleared and `status_o[10:8]` keeps its previous value.
- R4: A scan takes effect at the clock edge that samples a control or data write. While scan is enabled and transmit ready is clear, a scan also runs at every edge. When transmit ready is set and no write occurs, the status word holds even if the mask changes.
- R5: A data write with `dat_odd`=0 sends a character to the line in `status_o[10:8]`, but only when scan is enabled and the output slot is free. The character appears on `tx_char`/`tx_line` with `tx_valid` after that edge. A write with `dat_odd`=1, or any write while scan is disabled, sends nothing.
- R6: With `mode_8bit`=0 the sent character is `dat_wdata` with bit 7 forced to 0. With `mode_8bit`=1 all 8 bits are sent.
- R7: A line that receives a character is not idle for BUSY_CYCLES edges. A scan at the edge that sends excludes that line. The line qualifies again from the (BUSY_CYCLES+1)th edge after the send.
- R8: `tx_irq_o` equals `status_o[6]` (interrupt enable) AND `status_o[15]`. A control write that sets the enable while ready is already set raises `tx_irq_o` after that same edge.
- R9: `status_o[0]` reflects scan enable and `status_o[6]` reflects interrupt enable. A control write with scan disabled clears `status_o[15]` and leaves the line field unchanged. All other status bits read 0.
- R10: While `tx_valid`=1 and `tx_ready`=0, `tx_valid`, `tx_line` and `tx_char` hold. A data write made in that state is not sent. `tx_valid` falls after an edge with `tx_ready`=1 unless a new character is sent at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txen_mask | input | NUM_LINES | Per-line transmit enable |
| mode_8bit | input | 1 | 1: send 8-bit characters, 0: mask to 7 bits |
| ctl_wr | input | 1 | Control write strobe |
| ctl_scan_en | input | 1 | Master scan enable value for a control write |
| ctl_int_en | input | 1 | Transmit interrupt enable value for a control write |
| dat_wr | input | 1 | Data write strobe |
| dat_odd | input | 1 | 1: high-byte write (nothing sent) |
| dat_wdata | input | 8 | Character byte |
| status_o | output | 16 | Status word: [15] ready, [10:8] line, [6] int enable, [0] scan enable |
| tx_irq_o | output | 1 | Transmit interrupt request |
| tx_valid | output | 1 | Character available on the output stream |
| tx_ready | input | 1 | Downstream accepts the character |
| tx_line | output | LINE_W | Destination line of the character |
| tx_char | output | 8 | Character |

## Verification
The bench builds the block with eight lines and BUSY_CYCLES of 4. Eight lines fill the whole three-bit line field, so the wrap from line 7 back to line 0 comes into play. A short busy window lets the bench watch a line drop out of the search and then return a few cycles later. With the mask held and a line still busy, the bench can show that an empty search keeps the line field. It can also show the hold of a ready status against a mask change, and an output slot that stalls under back-pressure.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int STAT_W      = 16;
  localparam int STAT_SCAN   = 0;
  localparam int STAT_INTEN  = 6;
  localparam int STAT_LINE_LO = 8;
  localparam int STAT_RDY    = 15;
  localparam int CHAR_W      = 8;

  function automatic logic [CHAR_W-1:0] fit_char(input logic [CHAR_W-1:0] d,
                                                 input logic wide);
    fit_char = wide ? d : {1'b0, d[CHAR_W-2:0]};
  endfunction
endpackage

// File: rtl/txs_busy_timers.sv
module txs_busy_timers #(
  parameter int NUM_LINES   = 8,
  parameter int BUSY_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] load,
  output logic [NUM_LINES-1:0] idle
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (load[g])
        cnt_q <= CW'(BUSY_CYCLES);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
    assign idle[g] = (cnt_q == '0);
  end
endmodule

// File: rtl/txs_rr_pick.sv
module txs_rr_pick #(
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = 3
) (
  input  logic [LINE_W-1:0]    last,
  input  logic [NUM_LINES-1:0] elig,
  output logic                 found,
  output logic [LINE_W-1:0]    pick
);
  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= NUM_LINES; k++) begin
      int idx;
      idx = (int'(last) + k) % NUM_LINES;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = LINE_W'(idx);
      end
    end
  end
endmodule

// File: rtl/txs_tx_slot.sv
module txs_tx_slot #(
  parameter int LINE_W = 3,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send,
  input  logic [LINE_W-1:0] send_line,
  input  logic [CHAR_W-1:0] send_char,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [LINE_W-1:0] out_line,
  output logic [CHAR_W-1:0] out_char,
  output logic              free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_line  <= '0;
      out_char  <= '0;
    end else if (send) begin
      out_valid <= 1'b1;
      out_line  <= send_line;
      out_char  <= send_char;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/txs_line_scanner.sv
module txs_line_scanner
  import txs_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int BUSY_CYCLES = 16,
  parameter int LINE_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] txen_mask,
  input  logic                 mode_8bit,
  input  logic                 ctl_wr,
  input  logic                 ctl_scan_en,
  input  logic                 ctl_int_en,
  input  logic                 dat_wr,
  input  logic                 dat_odd,
  input  logic [7:0]           dat_wdata,
  output logic [15:0]          status_o,
  output logic                 tx_irq_o,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [LINE_W-1:0]    tx_line,
  output logic [7:0]           tx_char
);
  logic                 scan_en_q, int_en_q, rdy_q, irq_q;
  logic [LINE_W-1:0]    line_q;
  logic                 scan_en_n, int_en_n, rdy_n;
  logic [LINE_W-1:0]    line_n;
  logic                 slot_free, send, do_scan, found;
  logic [LINE_W-1:0]    pick;
  logic [NUM_LINES-1:0] idle, load, elig;

  assign scan_en_n = ctl_wr ? ctl_scan_en : scan_en_q;
  assign int_en_n  = ctl_wr ? ctl_int_en  : int_en_q;
  assign send      = dat_wr && !dat_odd && scan_en_q && slot_free;
  assign load      = send ? (NUM_LINES'(1) << line_q) : '0;
  assign elig      = txen_mask & idle & ~load;
  assign do_scan   = ctl_wr || dat_wr || !rdy_q;

  txs_busy_timers #(.NUM_LINES(NUM_LINES), .BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(load), .idle(idle));

  txs_rr_pick #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_pick (
    .last(line_q), .elig(elig), .found(found), .pick(pick));

  txs_tx_slot #(.LINE_W(LINE_W), .CHAR_W(CHAR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .send(send), .send_line(line_q),
    .send_char(fit_char(dat_wdata, mode_8bit)), .out_ready(tx_ready),
    .out_valid(tx_valid), .out_line(tx_line), .out_char(tx_char),
    .free(slot_free));

  always_comb begin
    rdy_n  = rdy_q;
    line_n = line_q;
    if (!scan_en_n) begin
      rdy_n = 1'b0;
    end else if (do_scan) begin
      rdy_n = found;
      if (found) line_n = pick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_en_q <= 1'b0;
      int_en_q  <= 1'b0;
      rdy_q     <= 1'b0;
      line_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      scan_en_q <= scan_en_n;
      int_en_q  <= int_en_n;
      rdy_q     <= rdy_n;
      line_q    <= line_n;
      irq_q     <= int_en_n && rdy_n;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[STAT_SCAN]  = scan_en_q;
    status_o[STAT_INTEN] = int_en_q;
    status_o[STAT_RDY]   = rdy_q;
    status_o[STAT_LINE_LO +: LINE_W] = line_q;
  end
  assign tx_irq_o = irq_q;
endmodule

// File: rtl/txs_line_scanner_chk.sv
module txs_line_scanner_chk #(
  parameter int LINE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       status_o,
  input logic              tx_irq_o,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [LINE_W-1:0] tx_line,
  input logic [7:0]        tx_char
);
  assert_pending_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_line) && $stable(tx_char)));

  assert_irq_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_o == (status_o[15] && status_o[6]));

  assert_scan_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[0] |-> !status_o[15]);

  assert_line_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[15]) |-> $stable(status_o[10:8]));

  assert_send_needs_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(status_o[0]));
endmodule

bind txs_line_scanner txs_line_scanner_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_o(status_o), .tx_irq_o(tx_irq_o),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line), .tx_char(tx_char));

// File: tb/txs_line_scanner_tb_top.sv
module txs_line_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] txen_mask = '0;
  logic          mode_8bit = 1'b0;
  logic          ctl_wr = 1'b0, ctl_scan_en = 1'b0, ctl_int_en = 1'b0;
  logic          dat_wr = 1'b0, dat_odd = 1'b0;
  logic [7:0]    dat_wdata = '0;
  logic [15:0]   status_o;
  logic          tx_irq_o, tx_valid;
  logic          tx_ready = 1'b1;
  logic [LW-1:0] tx_line;
  logic [7:0]    tx_char;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txs_line_scanner #(.NUM_LINES(NL), .BUSY_CYCLES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .txen_mask(txen_mask), .mode_8bit(mode_8bit),
    .ctl_wr(ctl_wr), .ctl_scan_en(ctl_scan_en), .ctl_int_en(ctl_int_en),
    .dat_wr(dat_wr), .dat_odd(dat_odd), .dat_wdata(dat_wdata),
    .status_o(status_o), .tx_irq_o(tx_irq_o), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_line(tx_line), .tx_char(tx_char));

  // op: 0 none, 1 control write, 2 data word write, 3 odd-byte write
  typedef struct packed {
    logic [1:0]  op;
    logic        scan;
    logic        ien;
    logic [7:0]  data;
    logic [7:0]  mask;
    logic        m8;
    logic [15:0] st;
    logic        irq;
    logic        vld;
    logic [2:0]  line;
    logic [7:0]  ch;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 16'h0001, 1'b0, 1'b0, 3'd0, 8'h00, 4'd3},
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h24, 1'b0, 16'h8201, 1'b0, 1'b0, 3'd0, 8'h00, 4'd4},
    '{2'd2, 1'b0, 1'b0, 8'hC1, 8'h24, 1'b0, 16'h8501, 1'b0, 1'b1, 3'd2, 8'h41, 4'd6},
    '{2'd2, 1'b0, 1'b0, 8'hC2, 8'h24, 1'b1, 16'h0501, 1'b0, 1'b1, 3'd5, 8'hC2, 4'd6},
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h24, 1'b0, 16'h0501, 1'b0, 1'b0, 3'd0, 8'h00, 4'd7},
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h24, 1'b0, 16'h0501, 1'b0, 1'b0, 3'd0, 8'h00, 4'd7},
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h24, 1'b0, 16'h0501, 1'b0, 1'b0, 3'd0, 8'h00, 4'd7},
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h24, 1'b0, 16'h8201, 1'b0, 1'b0, 3'd0, 8'h00, 4'd7},
    '{2'd3, 1'b0, 1'b0, 8'h33, 8'h24, 1'b0, 16'h8501, 1'b0, 1'b0, 3'd0, 8'h00, 4'd5},
    '{2'd1, 1'b1, 1'b1, 8'h00, 8'h24, 1'b0, 16'h8241, 1'b1, 1'b0, 3'd0, 8'h00, 4'd2},
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 16'h8241, 1'b1, 1'b0, 3'd0, 8'h00, 4'd4},
    '{2'd1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 16'h0240, 1'b0, 1'b0, 3'd0, 8'h00, 4'd9},
    '{2'd2, 1'b0, 1'b0, 8'h55, 8'h00, 1'b0, 16'h0240, 1'b0, 1'b0, 3'd0, 8'h00, 4'd5},
    '{2'd1, 1'b1, 1'b0, 8'h00, 8'h80, 1'b0, 16'h8701, 1'b0, 1'b0, 3'd0, 8'h00, 4'd2},
    '{2'd1, 1'b1, 1'b1, 8'h00, 8'h80, 1'b0, 16'h8741, 1'b1, 1'b0, 3'd0, 8'h00, 4'd8},
    '{2'd2, 1'b0, 1'b0, 8'hFF, 8'h80, 1'b0, 16'h0741, 1'b0, 1'b1, 3'd7, 8'h7F, 4'd6}
  };

  function automatic string rq_name(input logic [3:0] r);
    case (r)
      4'd1: rq_name = "R1";   4'd2: rq_name = "R2";   4'd3: rq_name = "R3";
      4'd4: rq_name = "R4";   4'd5: rq_name = "R5";   4'd6: rq_name = "R6";
      4'd7: rq_name = "R7";   4'd8: rq_name = "R8";   4'd9: rq_name = "R9";
      default: rq_name = "R10";
    endcase
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive_clear();
    ctl_wr = 1'b0; dat_wr = 1'b0; dat_odd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "status", 32'(status_o), 32'h0);
    check("R1", "irq", 32'(tx_irq_o), 32'h0);
    check("R1", "valid", 32'(tx_valid), 32'h0);

    // vector walk: drive row, one edge, check after it
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive_clear();
      txen_mask = v.mask;
      mode_8bit = v.m8;
      case (v.op)
        2'd1: begin ctl_wr = 1'b1; ctl_scan_en = v.scan; ctl_int_en = v.ien; end
        2'd2: begin dat_wr = 1'b1; dat_wdata = v.data; end
        2'd3: begin dat_wr = 1'b1; dat_odd = 1'b1; dat_wdata = v.data; end
        default: ;
      endcase
      @(negedge clk);
      check(rq_name(v.rq), $sformatf("row %0d status", i), 32'(status_o), 32'(v.st));
      check("R8", $sformatf("row %0d irq", i), 32'(tx_irq_o), 32'(v.irq));
      check("R5", $sformatf("row %0d valid", i), 32'(tx_valid), 32'(v.vld));
      if (v.vld) begin
        check("R5", $sformatf("row %0d line", i), 32'(tx_line), 32'(v.line));
        check(rq_name(v.rq), $sformatf("row %0d char", i), 32'(tx_char), 32'(v.ch));
      end
    end
    drive_clear();

    // directed: second reset returns everything to the R1 state
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", "status after re-reset", 32'(status_o), 32'h0);
    check("R1", "valid after re-reset", 32'(tx_valid), 32'h0);

    // directed: back-pressure on the output stream (R10)
    txen_mask = 8'h03;
    tx_ready = 1'b0;
    ctl_wr = 1'b1; ctl_scan_en = 1'b1; ctl_int_en = 1'b0;
    @(negedge clk);
    drive_clear();
    check("R2", "bp scan picks line1", 32'(status_o), 32'h8101);
    dat_wr = 1'b1; dat_wdata = 8'h11;
    @(negedge clk);
    check("R10", "bp first send valid", 32'(tx_valid), 32'h1);
    check("R10", "bp first send line", 32'(tx_line), 32'h1);
    check("R2", "bp rescan wraps to line0", 32'(status_o), 32'h8001);
    dat_wdata = 8'h22;
    @(negedge clk);
    drive_clear();
    check("R10", "bp held valid", 32'(tx_valid), 32'h1);
    check("R10", "bp held char", 32'(tx_char), 32'h11);
    check("R10", "bp held line", 32'(tx_line), 32'h1);
    check("R2", "bp status", 32'(status_o), 32'h8001);
    tx_ready = 1'b1;
    @(negedge clk);
    check("R10", "bp accepted", 32'(tx_valid), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule